// File: doc/BRIEF.md
# Power Key Press Classifier

This block watches a single mechanical power key and sorts every press by how long it is held. The raw key level, active high, is brought into the clock domain through a two-flop synchronizer. It is then filtered so that only a level held steady for a set number of millisecond ticks is accepted. Each accepted rising and falling edge is reported as a one-cycle pulse.

When the key goes down, a duration timer is loaded with a programmable threshold, counted in millisecond ticks from an internal clock divider. If the key comes back up before the timer runs out, the press is short. If the timer runs out while the key is still down, the press is long. That happens once per press, and the later release is not reported as short.

A small policy stage gives each result its meaning from the current power state. While the system is off, a long press asks for power-on, and a press that is too short asks for the boot to be abandoned. While the system is on, a long press raises a shutdown interrupt toward the processor, and a short press has no power effect. A typical threshold is 1000 ticks, which is one second.

Top module: `pwrkey_classifier`

## Requirements
- R1: During reset and until the first accepted key edge, all seven pulse outputs stay low and the timer is idle.
- R2: Each accepted key-down gives exactly one single-cycle `press_p`, and each accepted key-up gives exactly one single-cycle `release_p`, however much the raw key bounces before settling.
- R3: A raw key level that differs from the accepted level for fewer than `DEBOUNCE_TICKS` millisecond ticks gives no edge pulse at all.
- R4: A release accepted before the timer expires gives exactly one `short_p`, one cycle after its `release_p`, and no `long_p`.
- R5: `long_p` rises exactly `threshold * CLK_PER_TICK` clock cycles after the `press_p` of the same press, and a threshold of 0 is treated as 1.
- R6: At most one `long_p` fires per press, and the release that follows a long press gives `release_p` but never `short_p`.
- R7: With `power_on` low, a long press gives one `pwr_on_req` pulse one cycle after `long_p`, and no `shutdown_irq`.
- R8: With `power_on` low, a short press gives one `boot_abort` pulse one cycle after `short_p`, and no `pwr_on_req`.
- R9: With `power_on` high, a long press gives one `shutdown_irq` pulse one cycle after `long_p`, and a short press gives no power output.
- R10: The threshold is captured when `press_p` fires, so changing `threshold` while the key is held does not move the `long_p` of that press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_raw | input | 1 | Raw power key level, high while pressed |
| threshold | input | THRESH_W | Short/long boundary in millisecond ticks |
| power_on | input | 1 | Current power state, high when the system is on |
| press_p | output | 1 | Accepted key-down pulse |
| release_p | output | 1 | Accepted key-up pulse |
| short_p | output | 1 | Short-press result pulse |
| long_p | output | 1 | Long-press result pulse |
| pwr_on_req | output | 1 | Power-on request pulse (off state, long press) |
| boot_abort | output | 1 | Abandon-boot request pulse (off state, short press) |
| shutdown_irq | output | 1 | Shutdown interrupt pulse (on state, long press) |

## Verification
The key is driven with a glitch shorter than the filter window, with a burst of bounces before a steady hold, with holds well below and well above the threshold, and with thresholds of 0, 1 and 10. Together these separate filter rejection from edge detection, and short results from long ones. The cycle distance from the press pulse to the long pulse is measured exactly, including a run where the threshold input changes mid-hold, which shows whether the timer uses the captured value. Each hold length is repeated with the power state low and high, which shows whether the policy stage routes a result to the right request.

// File: rtl/pwrkey_pkg.sv
package pwrkey_pkg;

  // Duration timer states
  typedef enum logic [1:0] {
    TMR_IDLE = 2'd0,  // key up, waiting for a press
    TMR_RUN  = 2'd1,  // key down, threshold not yet reached
    TMR_HELD = 2'd2   // long result given, waiting for release
  } tmr_state_e;

endpackage

// File: rtl/pwrkey_tick_gen.sv
// Free-running divider giving a one-cycle enable every DIV clocks.
module pwrkey_tick_gen #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(DIV - 1));
  assign tick_o = wrap;

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pwrkey_debounce.sv
// Two-flop synchronizer, stable-level filter counted in ticks, edge pulses.
module pwrkey_debounce #(
  parameter int unsigned DB_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic key_i,
  output logic rise_o,
  output logic fall_o
);

  localparam int unsigned DW = $clog2(DB_TICKS + 1);

  logic          sync1_q, sync2_q;
  logic          level_q, level_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          rise_q, rise_d, fall_q, fall_d;
  logic          differ, flip;

  assign differ = sync2_q ^ level_q;
  assign flip   = differ && tick_i && (cnt_q == DW'(DB_TICKS - 1));

  always_comb begin
    if (!differ)      cnt_d = '0;
    else if (flip)    cnt_d = '0;
    else if (tick_i)  cnt_d = cnt_q + DW'(1);
    else              cnt_d = cnt_q;
    level_d = flip ? sync2_q : level_q;
    rise_d  = flip &&  sync2_q;
    fall_d  = flip && !sync2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      level_q <= 1'b0;
      cnt_q   <= '0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      sync1_q <= key_i;
      sync2_q <= sync1_q;
      level_q <= level_d;
      cnt_q   <= cnt_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;

endmodule

// File: rtl/pwrkey_press_timer.sv
// Loads the threshold on press, counts ticks down, decides short or long.
module pwrkey_press_timer
  import pwrkey_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [TW-1:0] threshold_i,
  output logic          short_o,
  output logic          long_o
);

  tmr_state_e    state_q, state_d;
  logic [TW-1:0] remain_q, remain_d;
  logic          short_q, short_d, long_q, long_d;

  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    short_d  = 1'b0;
    long_d   = 1'b0;
    unique case (state_q)
      TMR_IDLE: begin
        if (rise_i) begin
          state_d  = TMR_RUN;
          remain_d = threshold_i;
        end
      end
      TMR_RUN: begin
        // release wins over expiry in the same cycle
        if (fall_i) begin
          short_d = 1'b1;
          state_d = TMR_IDLE;
        end else if (tick_i) begin
          if (remain_q <= TW'(1)) begin
            long_d  = 1'b1;
            state_d = TMR_HELD;
          end else begin
            remain_d = remain_q - TW'(1);
          end
        end
      end
      TMR_HELD: begin
        if (fall_i) state_d = TMR_IDLE;
      end
      default: state_d = TMR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= TMR_IDLE;
      remain_q <= '0;
      short_q  <= 1'b0;
      long_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
      short_q  <= short_d;
      long_q   <= long_d;
    end
  end

  assign short_o = short_q;
  assign long_o  = long_q;

endmodule

// File: rtl/pwrkey_power_policy.sv
// Maps short/long results to power requests according to the power state.
module pwrkey_power_policy (
  input  logic clk,
  input  logic rst_n,
  input  logic short_i,
  input  logic long_i,
  input  logic power_on_i,
  output logic pwr_on_req_o,
  output logic boot_abort_o,
  output logic shutdown_irq_o
);

  logic on_req_q, on_req_d, abort_q, abort_d, irq_q, irq_d;

  always_comb begin
    on_req_d = long_i  && !power_on_i;
    abort_d  = short_i && !power_on_i;
    irq_d    = long_i  &&  power_on_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_req_q <= 1'b0;
      abort_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      on_req_q <= on_req_d;
      abort_q  <= abort_d;
      irq_q    <= irq_d;
    end
  end

  assign pwr_on_req_o   = on_req_q;
  assign boot_abort_o   = abort_q;
  assign shutdown_irq_o = irq_q;

endmodule

// File: rtl/pwrkey_classifier.sv
module pwrkey_classifier #(
  parameter int unsigned CLK_PER_TICK   = 50000,
  parameter int unsigned DEBOUNCE_TICKS = 20,
  parameter int unsigned THRESH_W       = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                key_raw,
  input  logic [THRESH_W-1:0] threshold,
  input  logic                power_on,
  output logic                press_p,
  output logic                release_p,
  output logic                short_p,
  output logic                long_p,
  output logic                pwr_on_req,
  output logic                boot_abort,
  output logic                shutdown_irq
);

  logic tick;
  logic rise, fall;

  pwrkey_tick_gen #(.DIV(CLK_PER_TICK)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  pwrkey_debounce #(.DB_TICKS(DEBOUNCE_TICKS)) u_deb (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .key_i  (key_raw),
    .rise_o (rise),
    .fall_o (fall)
  );

  pwrkey_press_timer #(.TW(THRESH_W)) u_tmr (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .rise_i      (rise),
    .fall_i      (fall),
    .threshold_i (threshold),
    .short_o     (short_p),
    .long_o      (long_p)
  );

  pwrkey_power_policy u_pol (
    .clk            (clk),
    .rst_n          (rst_n),
    .short_i        (short_p),
    .long_i         (long_p),
    .power_on_i     (power_on),
    .pwr_on_req_o   (pwr_on_req),
    .boot_abort_o   (boot_abort),
    .shutdown_irq_o (shutdown_irq)
  );

  assign press_p   = rise;
  assign release_p = fall;

endmodule

// File: rtl/pwrkey_classifier_chk.sv
module pwrkey_classifier_chk (
  input logic clk,
  input logic rst_n,
  input logic power_on,
  input logic press_p,
  input logic release_p,
  input logic short_p,
  input logic long_p,
  input logic pwr_on_req,
  input logic boot_abort,
  input logic shutdown_irq
);

  // set by a long result, cleared by the next press
  logic seen_long_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_long_q <= 1'b0;
    else if (press_p) seen_long_q <= 1'b0;
    else if (long_p)  seen_long_q <= 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !(press_p || release_p || short_p || long_p || pwr_on_req || boot_abort || shutdown_irq)); // R1
  AST_PRESS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) press_p |=> !press_p); // R2
  AST_RELEASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) release_p |=> !release_p); // R2
  AST_SHORT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) short_p |-> $past(release_p)); // R4
  AST_NO_SHORT_AFTER_LONG: assert property (@(posedge clk) disable iff (!rst_n) short_p |-> !seen_long_q); // R6
  AST_ONE_LONG_PER_PRESS: assert property (@(posedge clk) disable iff (!rst_n) long_p |-> !seen_long_q); // R6
  AST_PWRON_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) pwr_on_req |-> ($past(long_p) && !$past(power_on))); // R7
  AST_PWRON_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (long_p && !power_on) |=> pwr_on_req); // R7
  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) boot_abort |-> ($past(short_p) && !$past(power_on))); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) shutdown_irq |-> ($past(long_p) && $past(power_on))); // R9

endmodule

bind pwrkey_classifier pwrkey_classifier_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .power_on     (power_on),
  .press_p      (press_p),
  .release_p    (release_p),
  .short_p      (short_p),
  .long_p       (long_p),
  .pwr_on_req   (pwr_on_req),
  .boot_abort   (boot_abort),
  .shutdown_irq (shutdown_irq)
);

// File: tb/tb_pwrkey_classifier.sv
module tb_pwrkey_classifier;

  localparam int CLK_PERIOD = 10;
  localparam int CPT        = 4;
  localparam int DBT        = 3;
  localparam int TW         = 16;

  logic          clk;
  logic          rst_n;
  logic          key_raw;
  logic [TW-1:0] threshold;
  logic          power_on;
  logic press_p, release_p, short_p, long_p, pwr_on_req, boot_abort, shutdown_irq;

  pwrkey_classifier #(
    .CLK_PER_TICK(CPT), .DEBOUNCE_TICKS(DBT), .THRESH_W(TW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .key_raw(key_raw), .threshold(threshold),
    .power_on(power_on), .press_p(press_p), .release_p(release_p),
    .short_p(short_p), .long_p(long_p), .pwr_on_req(pwr_on_req),
    .boot_abort(boot_abort), .shutdown_irq(shutdown_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk, n_err;
  int cyc;
  int n_press, n_rel, n_short, n_long, n_on, n_abort, n_irq;
  int t_press, t_rel, t_short, t_long, t_on, t_abort, t_irq;
  bit finished;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (press_p)      begin n_press++; t_press = cyc; end
      if (release_p)    begin n_rel++;   t_rel   = cyc; end
      if (short_p)      begin n_short++; t_short = cyc; end
      if (long_p)       begin n_long++;  t_long  = cyc; end
      if (pwr_on_req)   begin n_on++;    t_on    = cyc; end
      if (boot_abort)   begin n_abort++; t_abort = cyc; end
      if (shutdown_irq) begin n_irq++;   t_irq   = cyc; end
    end
  end

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_press = 0; n_rel = 0; n_short = 0; n_long = 0; n_on = 0; n_abort = 0; n_irq = 0;
  endtask

  task automatic hold_key(input int cycles);
    @(negedge clk) key_raw = 1'b1;
    repeat (cycles) @(negedge clk);
    key_raw = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    int bad;
    bad = 0;
    rst_n = 1'b0;
    repeat (5) begin
      @(negedge clk);
      bad += int'(press_p) + int'(release_p) + int'(short_p) + int'(long_p)
           + int'(pwr_on_req) + int'(boot_abort) + int'(shutdown_irq);
    end
    chk_eq("R1", "outputs high during reset", bad, 0);
    rst_n = 1'b1;
    clear_counts();
    repeat (40) @(negedge clk);
    chk_eq("R1", "pulses while idle after reset", n_press + n_rel + n_short + n_long + n_on + n_abort + n_irq, 0);
  endtask

  // R3: glitch shorter than the filter window
  task automatic t_glitch();
    clear_counts();
    hold_key(2 * CPT);
    chk_eq("R3", "press count after glitch", n_press, 0);
    chk_eq("R3", "release count after glitch", n_rel, 0);
  endtask

  // R2: bounces before a steady hold give one press and one release
  task automatic t_bounce();
    clear_counts();
    power_on = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) key_raw = 1'b1;
      repeat (3) @(negedge clk);
      key_raw = 1'b0;
      repeat (2) @(negedge clk);
    end
    hold_key(25 * CPT);
    chk_eq("R2", "press count with bounce", n_press, 1);
    chk_eq("R2", "release count with bounce", n_rel, 1);
  endtask

  // R4, R8: short press while off
  task automatic t_short_off();
    clear_counts();
    power_on = 1'b0;
    threshold = TW'(10);
    hold_key(5 * CPT);
    chk_eq("R4", "short count", n_short, 1);
    chk_eq("R4", "long count on short press", n_long, 0);
    chk_eq("R4", "short delay after release", t_short - t_rel, 1);
    chk_eq("R8", "boot_abort count", n_abort, 1);
    chk_eq("R8", "boot_abort delay after short", t_abort - t_short, 1);
    chk_eq("R8", "pwr_on_req on short press", n_on, 0);
  endtask

  // R5, R6, R7: long press while off
  task automatic t_long_off();
    clear_counts();
    power_on = 1'b0;
    threshold = TW'(10);
    hold_key(25 * CPT);
    chk_eq("R5", "press to long cycles", t_long - t_press, 10 * CPT);
    chk_eq("R6", "long count", n_long, 1);
    chk_eq("R6", "short count after long", n_short, 0);
    chk_eq("R6", "release count after long", n_rel, 1);
    chk_eq("R7", "pwr_on_req count", n_on, 1);
    chk_eq("R7", "pwr_on_req delay after long", t_on - t_long, 1);
    chk_eq("R7", "shutdown_irq while off", n_irq, 0);
  endtask

  // R9: long and short press while on
  task automatic t_on_state();
    clear_counts();
    power_on = 1'b1;
    threshold = TW'(10);
    hold_key(25 * CPT);
    chk_eq("R9", "shutdown_irq count", n_irq, 1);
    chk_eq("R9", "shutdown_irq delay after long", t_irq - t_long, 1);
    chk_eq("R9", "pwr_on_req while on", n_on, 0);
    clear_counts();
    hold_key(5 * CPT);
    chk_eq("R9", "short seen while on", n_short, 1);
    chk_eq("R9", "power outputs on short while on", n_on + n_abort + n_irq, 0);
  endtask

  // R10: threshold change during hold is ignored
  task automatic t_thresh_capture();
    int guard;
    clear_counts();
    power_on = 1'b1;
    threshold = TW'(10);
    @(negedge clk) key_raw = 1'b1;
    guard = 0;
    while (n_press == 0 && guard < 200) begin @(negedge clk); guard++; end
    threshold = TW'(3);
    repeat (25 * CPT) @(negedge clk);
    key_raw = 1'b0;
    repeat (60) @(negedge clk);
    chk_eq("R10", "press to long with mid-hold change", t_long - t_press, 10 * CPT);
    threshold = TW'(10);
  endtask

  // R5: threshold 1 and threshold 0
  task automatic t_small_thresh();
    power_on = 1'b1;
    clear_counts();
    threshold = TW'(1);
    hold_key(8 * CPT);
    chk_eq("R5", "press to long at threshold 1", t_long - t_press, CPT);
    clear_counts();
    threshold = TW'(0);
    hold_key(8 * CPT);
    chk_eq("R5", "press to long at threshold 0", t_long - t_press, CPT);
    chk_eq("R5", "long count at threshold 0", n_long, 1);
    threshold = TW'(10);
  endtask

  initial begin
    n_chk = 0; n_err = 0; cyc = 0; finished = 1'b0;
    key_raw = 1'b0; power_on = 1'b0; threshold = TW'(10);
    clear_counts();
    t_press = 0; t_rel = 0; t_short = 0; t_long = 0; t_on = 0; t_abort = 0; t_irq = 0;
    t_reset();
    t_glitch();
    t_short_off();
    t_long_off();
    t_on_state();
    t_thresh_capture();
    t_small_thresh();
    t_bounce();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

endmodule